// File: doc/BRIEF.md
# Inverting Scan Chain with Stuck-Cell Locator

This block is a scan chain of `N` cells in which every cell can take functional data, take the bit of its upstream neighbour, or flip its own stored bit in place. Cell 0 is the one fed by scan-in. Cell `N-1` drives scan-out. A locator watches the scan-out stream after an in-place flip and reports which cell is stuck.

The diagnosis runs in three steps. First, fill the chain with a constant: ones when hunting a stuck-at-0 cell, zeros for a stuck-at-1 cell. Second, apply one cycle of invert with scan-enable low. Third, unload `N` bits. The stuck cell blocks the fill value from reaching the cells downstream of it. After the flip, those downstream cells hold the fill value, while the cells at and upstream of the defect read as its complement. The locator measures how long the first run of equal bits lasts and converts that length into a cell index.

A per-cell injection port forces a cell's output to a constant so that defects can be modelled. It does not disturb the cell's stored bit.

Top module: `invscan_locator`

## Requirements
- R1: While rst_n is low at a clock edge, every cell's stored bit becomes 0 and res_valid and res_none become 0.
- R2: With scan_en=0 and invert=0, each clock edge loads func_d[i] into cell i. Cell 0 is nearest scan-in, and cell N-1 drives scan_out.
- R3: With scan_en=1, each edge moves cell i into cell i+1 and scan_in into cell 0. The first bit shifted in ends up in cell N-1 after N shifts, and scan_out shows cell N-1 first during unload.
- R4: With scan_en=0 and invert=1, one edge complements every cell's stored bit.
- R5: When scan_en=1 the invert input has no effect. The edge shifts, and a held locator result stays valid.
- R6: stuck_en[i]=1 makes cell i present stuck_val[i] to its neighbour and to scan_out, without changing its stored bit. Releasing stuck_en[i] shows the stored bit at once.
- R7: For a stuck-at-0 cell k with k ≤ N-2, the sequence (shift in N ones, one invert cycle, N unload shifts) leaves res_valid=1, res_none=0 and res_index=k.
- R8: The mirror sequence (shift in N zeros, invert, unload N) reports a stuck-at-1 cell k ≤ N-2 as res_index=k.
- R9: When the scan_out value does not change within the N unload samples after an invert, the locator reports res_valid=1, res_none=1 and res_index=0. This covers a defect-free chain and a stuck cell N-1.
- R10: An accepted invert (scan_en=0) clears res_valid and res_none and arms the locator. The result is then held until the next accepted invert.
- R11: Both end positions that can be located are reported correctly: cell 0, seen on the last unload sample, and cell N-2, seen on the second sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | Shift mode; overrides invert |
| scan_in | input | 1 | Serial input to cell 0 |
| invert | input | 1 | In-place flip of all cells (when scan_en=0); arms locator |
| func_d | input | N | Functional capture data, bit i to cell i |
| stuck_en | input | N | Per-cell defect injection enable |
| stuck_val | input | N | Forced output value for each injected cell |
| scan_out | output | 1 | Serial output from cell N-1 |
| res_valid | output | 1 | Locator result is available |
| res_none | output | 1 | No value change was seen during unload |
| res_index | output | $clog2(N) | Stuck cell index counted from scan-in |

## Verification
The hardest condition to reach is a result that depends on exactly where the defect sits relative to the chain ends. A fault at cell 0 only shows up on the very last unload sample. A fault at cell N-1 produces no edge at all, so its stream looks the same as a defect-free chain. The bench reaches these cases by driving the injection port for one chosen cell and polarity, then running the full fill, invert and unload sequence through the ports. It also checks the interior cases and confirms that an invert issued during shifting disturbs neither the shifted image nor the held result.

// File: rtl/invscan_pkg.sv
// Shared types for the inverting scan chain.
package invscan_pkg;
    // Per-cell next-state source.
    typedef enum logic [1:0] {
        MODE_FUNC  = 2'd0,
        MODE_SHIFT = 2'd1,
        MODE_FLIP  = 2'd2
    } cell_mode_e;
endpackage

// File: rtl/invscan_cell.sv
// One scan cell with three next-state sources: functional data, upstream
// neighbour, or the complement of its own stored bit.
// Assumes: the injection forces only the visible output, never the stored bit.
module invscan_cell
    import invscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cell_mode_e mode,
    input  logic       func_bit,
    input  logic       up_bit,
    input  logic       stuck_en,
    input  logic       stuck_val,
    output logic       q_out
);
    logic st;

    // Store the bit selected by the current mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= 1'b0;
        end else begin
            case (mode)
                MODE_FUNC:  st <= func_bit;
                MODE_SHIFT: st <= up_bit;
                MODE_FLIP:  st <= ~st;
                default:    st <= st;
            endcase
        end
    end

    // Visible value: forced by a modelled defect, else the stored bit.
    assign q_out = stuck_en ? stuck_val : st;
endmodule

// File: rtl/invscan_chain.sv
// N cells in series; cell 0 is fed by scan_in and cell N-1 drives scan_out.
// Assumes: all cells share one mode each cycle.
module invscan_chain
    import invscan_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cell_mode_e   mode,
    input  logic         scan_in,
    input  logic [N-1:0] func_d,
    input  logic [N-1:0] stuck_en,
    input  logic [N-1:0] stuck_val,
    output logic [N-1:0] cell_q,
    output logic         scan_out
);
    // Build the chain; each cell's upstream source is the previous cell.
    for (genvar gi = 0; gi < N; gi++) begin : g_cell
        logic up;
        if (gi == 0) begin : g_head
            assign up = scan_in;
        end else begin : g_body
            assign up = cell_q[gi-1];
        end
        invscan_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode),
            .func_bit  (func_d[gi]),
            .up_bit    (up),
            .stuck_en  (stuck_en[gi]),
            .stuck_val (stuck_val[gi]),
            .q_out     (cell_q[gi])
        );
    end

    assign scan_out = cell_q[N-1];
endmodule

// File: rtl/invscan_finder.sv
// Watches the unloaded stream after an in-place flip and locates the first
// change of value. A change at sample t (t >= 1) points at cell N-1-t.
// Assumes: arm is one cycle with no shift; samples are taken on shift cycles.
module invscan_finder #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          obs_en,
    input  logic          obs_bit,
    output logic          res_valid,
    output logic          res_none,
    output logic [IW-1:0] res_index
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic          active;
    logic [IW-1:0] cnt;
    logic          prev;

    // Arm on a flip, then count samples until a change or N samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cnt       <= '0;
            prev      <= 1'b0;
            res_valid <= 1'b0;
            res_none  <= 1'b0;
            res_index <= '0;
        end else if (arm) begin
            active    <= 1'b1;
            cnt       <= '0;
            res_valid <= 1'b0;
            res_none  <= 1'b0;
            res_index <= '0;
        end else if (active && obs_en) begin
            if (cnt == '0) begin
                prev <= obs_bit;
                cnt  <= cnt + 1'b1;
            end else if (obs_bit != prev) begin
                res_valid <= 1'b1;
                res_index <= LAST - cnt;
                active    <= 1'b0;
            end else if (cnt == LAST) begin
                res_valid <= 1'b1;
                res_none  <= 1'b1;
                active    <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/invscan_locator.sv
// Top: inverting scan chain plus stuck-cell locator.
// Assumes: scan_en has priority over invert; an invert only counts with
// scan_en low, and such an invert also arms the locator.
module invscan_locator
    import invscan_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_en,
    input  logic          scan_in,
    input  logic          invert,
    input  logic [N-1:0]  func_d,
    input  logic [N-1:0]  stuck_en,
    input  logic [N-1:0]  stuck_val,
    output logic          scan_out,
    output logic          res_valid,
    output logic          res_none,
    output logic [IW-1:0] res_index
);
    cell_mode_e   mode;
    logic         flip_go;
    logic [N-1:0] cell_q;

    // Pick the cell mode; shifting wins over a flip request.
    always_comb begin
        if (scan_en)     mode = MODE_SHIFT;
        else if (invert) mode = MODE_FLIP;
        else             mode = MODE_FUNC;
    end

    assign flip_go = invert && !scan_en;

    invscan_chain #(.N(N)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .scan_in   (scan_in),
        .func_d    (func_d),
        .stuck_en  (stuck_en),
        .stuck_val (stuck_val),
        .cell_q    (cell_q),
        .scan_out  (scan_out)
    );

    invscan_finder #(.N(N), .IW(IW)) u_finder (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (flip_go),
        .obs_en    (scan_en),
        .obs_bit   (scan_out),
        .res_valid (res_valid),
        .res_none  (res_none),
        .res_index (res_index)
    );
endmodule

// File: rtl/invscan_locator_chk.sv
// Property checker attached to invscan_locator.
module invscan_locator_chk #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scan_en,
    input logic          scan_in,
    input logic          invert,
    input logic [N-1:0]  stuck_en,
    input logic [N-1:0]  stuck_val,
    input logic [N-1:0]  cell_q,
    input logic          scan_out,
    input logic          res_valid,
    input logic          res_none,
    input logic [IW-1:0] res_index
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_none));

    a_r3_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (stuck_en[0] || cell_q[0] == $past(scan_in)));

    a_r4_flip_head: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && invert) |=>
            (stuck_en[0] || $past(stuck_en[0]) || cell_q[0] != $past(cell_q[0])));

    a_r5_invert_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && invert && res_valid) |=> res_valid);

    a_r6_forced_out: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_en[N-1] |-> (scan_out == stuck_val[N-1]));

    a_r7_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_none) |-> (res_index <= IW'(N - 2)));

    a_r9_none_form: assert property (@(posedge clk) disable iff (!rst_n)
        res_none |-> (res_valid && res_index == '0));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !(invert && !scan_en)) |=>
            (res_valid && $stable(res_index) && $stable(res_none)));
endmodule

bind invscan_locator invscan_locator_chk #(.N(N), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .scan_in   (scan_in),
    .invert    (invert),
    .stuck_en  (stuck_en),
    .stuck_val (stuck_val),
    .cell_q    (cell_q),
    .scan_out  (scan_out),
    .res_valid (res_valid),
    .res_none  (res_none),
    .res_index (res_index)
);

// File: tb/invscan_locator_bench.sv
// Directed bench: inputs are driven and outputs sampled at falling edges.
module invscan_locator_bench;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_en = 1'b0;
    logic          scan_in = 1'b0;
    logic          invert = 1'b0;
    logic [N-1:0]  func_d = '0;
    logic [N-1:0]  stuck_en = '0;
    logic [N-1:0]  stuck_val = '0;
    logic          scan_out;
    logic          res_valid;
    logic          res_none;
    logic [IW-1:0] res_index;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    invscan_locator #(.N(N)) u_invscan_locator (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_en   (scan_en),
        .scan_in   (scan_in),
        .invert    (invert),
        .func_d    (func_d),
        .stuck_en  (stuck_en),
        .stuck_val (stuck_val),
        .scan_out  (scan_out),
        .res_valid (res_valid),
        .res_none  (res_none),
        .res_index (res_index)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Shift a pattern in; bit N-1 goes first so it lands in cell N-1.
    task automatic load(input logic [N-1:0] pat);
        for (int i = 0; i < N; i++) begin
            scan_en = 1'b1; invert = 1'b0; scan_in = pat[N-1-i];
            @(negedge clk);
        end
    endtask

    // Shift the chain out; the first sample is cell N-1.
    task automatic unload(output logic [N-1:0] img);
        for (int i = 0; i < N; i++) begin
            img[N-1-i] = scan_out;
            scan_en = 1'b1; invert = 1'b0; scan_in = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic flip();
        scan_en = 1'b0; invert = 1'b1;
        @(negedge clk);
        invert = 1'b0; scan_en = 1'b1;
    endtask

    task automatic t_reset();
        logic [N-1:0] img;
        check(res_valid == 1'b0 && res_none == 1'b0, "R1 result flags", {res_valid, res_none}, 0);
        unload(img);
        check(img == '0, "R1 cells cleared", img, 0);
    endtask

    task automatic t_capture();
        logic [N-1:0] img;
        scan_en = 1'b0; invert = 1'b0; func_d = 8'hA5;
        @(negedge clk);
        check(scan_out == 1'b1, "R2 scan_out shows cell N-1", scan_out, 1);
        unload(img);
        check(img == 8'hA5, "R2 capture image", img, 8'hA5);
    endtask

    task automatic t_shift();
        logic [N-1:0] img;
        load(8'h3C);
        unload(img);
        check(img == 8'h3C, "R3 shift round trip", img, 8'h3C);
        load(8'h01);
        unload(img);
        check(img == 8'h01, "R3 first-in bit travels farthest", img, 8'h01);
    endtask

    task automatic t_flip();
        logic [N-1:0] img;
        load(8'h96);
        flip();
        unload(img);
        check(img == 8'h69, "R4 in-place flip", img, 8'h69);
    endtask

    task automatic t_ignore();
        logic [N-1:0] img;
        load(8'hF0);
        check(res_valid == 1'b1, "R5 result held before", res_valid, 1);
        scan_en = 1'b1; invert = 1'b1; scan_in = 1'b0;
        @(negedge clk);
        invert = 1'b0;
        check(res_valid == 1'b1, "R5 invert during shift does not arm", res_valid, 1);
        unload(img);
        check(img == 8'hE0, "R5 invert during shift just shifts", img, 8'hE0);
    endtask

    task automatic t_inject();
        scan_en = 1'b0; invert = 1'b0; func_d = 8'h80;
        stuck_en = 8'h80; stuck_val = 8'h00;
        @(negedge clk);
        check(scan_out == 1'b0, "R6 forced output", scan_out, 0);
        stuck_en = '0; scan_en = 1'b1;
        #1;
        check(scan_out == 1'b1, "R6 stored bit untouched", scan_out, 1);
        @(negedge clk);
    endtask

    task automatic t_locate(input int k, input bit sv, input bit expect_none,
                            input string req);
        logic [N-1:0] img;
        stuck_en = '0; stuck_val = '0;
        stuck_en[k] = 1'b1; stuck_val[k] = sv;
        load({N{~sv}});
        flip();
        check(res_valid == 1'b0, "R10 accepted invert clears result", res_valid, 0);
        unload(img);
        check(res_valid == 1'b1, req, res_valid, 1);
        check(res_none == expect_none, req, res_none, expect_none);
        check(res_index == (expect_none ? 0 : k), req, res_index, expect_none ? 0 : k);
        load(8'h5A);
        check(res_valid == 1'b1 && res_index == (expect_none ? 0 : k),
              "R10 result held across shifting", res_index, expect_none ? 0 : k);
        stuck_en = '0; stuck_val = '0;
    endtask

    task automatic t_clean();
        logic [N-1:0] img;
        stuck_en = '0;
        load({N{1'b1}});
        flip();
        unload(img);
        check(res_valid == 1'b1 && res_none == 1'b1 && res_index == 0,
              "R9 defect-free chain", {res_valid, res_none, res_index}, {2'b11, 3'd0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_capture();
        t_shift();
        t_flip();
        t_ignore();
        t_inject();
        t_locate(3, 1'b0, 1'b0, "R7 stuck-at-0 cell 3");
        t_locate(5, 1'b1, 1'b0, "R8 stuck-at-1 cell 5");
        t_locate(0, 1'b0, 1'b0, "R11 stuck-at-0 cell 0");
        t_locate(N-2, 1'b1, 1'b0, "R11 stuck-at-1 cell N-2");
        t_locate(N-1, 1'b0, 1'b1, "R9 stuck cell N-1 gives no edge");
        t_clean();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule